// File: doc/BRIEF.md
# I2C Target Front End for a 128-Step Digital Potentiometer

This block is an I2C target that sets the wiper of a 128-step digital potentiometer. It oversamples the bus clock and data lines with the system clock and pulls SDA low through an open-drain enable. Two strap pins set the low part of its bus address, so up to four of these blocks can share one bus. Registers are not reached through a flat map. A write-only steering register at register address 02h chooses where later accesses at register address 00h go: either the live wiper register or the stored-data register.

A controller first writes a register address. It can then send data bytes in the same transfer, or issue a repeated START and read. The block remembers the last register address it received across transfers. The wiper register drives the 7-bit tap output. Both the wiper register and the stored-data register reset to mid-scale.

Top module: `pot_i2c_front`

## Requirements
- R1: An address byte acknowledges only when its upper five bits are 01010, bits 2:1 equal the strap pins {strap_i[1], strap_i[0]}, and bit 0 is the direction (0 write, 1 read). The ACK is SDA held low during the ninth clock.
- R2: A non-matching address byte is not acknowledged. SDA stays released for the rest of that transfer, and no register changes.
- R3: In a write transfer, the register address byte and every data byte after it are acknowledged.
- R4: A data byte written at register address 02h sets the steering register. 80h selects the wiper register, 00h selects the stored-data register, and any other value leaves the selection unchanged.
- R5: A data byte written at register address 00h loads its low 7 bits into the selected register. The tap output follows the wiper register only. Data written at any other register address is discarded.
- R6: A read, when the last register address is 00h, returns the selected register MSB first, with bit 7 as 0. Each byte the controller acknowledges is followed by another copy.
- R7: A read, when the last register address is anything other than 00h (including the steering register 02h), leaves SDA released for all data bits, so the controller sees FFh.
- R8: After the controller NACKs a read byte, SDA stays released until the next START.
- R9: A STOP or a repeated START at any bit position ends the current byte sequence. Register contents and the last register address are kept.
- R10: After reset, the selection points at the wiper register, both registers hold 40h, and SDA is released.
- R11: The SDA drive enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock level |
| sda_i | input | 1 | Sampled bus data level |
| strap_i | input | 2 | Address strap pins, compared with address bits 2:1 |
| sda_oe_o | output | 1 | Pulls SDA low when 1, releases it when 0 |
| wiper_o | output | 7 | Current wiper tap setting |

## Verification
A table of three-byte writes exercises the address decoder in several ways: a matching address, an address with the wrong strap bits, and an address with the wrong device-type bits. These show whether all three fields of the address byte are compared. The same table writes the steering register with 80h, 00h and an unknown code, then writes register address 00h. The resulting tap output separates a wiper update from a stored-data update and from a change of selection. Directed reads then tell apart data returned for register 00h under each selection, the all-ones result for the steering register, continued bytes after a controller ACK, and the release after a NACK. Aborted bytes and a mid-run reset show that STOP handling, START handling and reset values are distinct from one another.

// File: rtl/pot_pkg.sv
package pot_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } eng_state_e;

endpackage

// File: rtl/pot_i2c_linemon.sv
module pot_i2c_linemon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [1:0] line_in;
  logic [1:0] cur;
  logic [1:0] prv;

  assign line_in = {scl_i, sda_i};

  // one oversampling pipe per bus line; idle bus level is high
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [PIPE_W-1:0] pipe_q;
    logic [PIPE_W-1:0] pipe_d;

    always_comb pipe_d = {pipe_q[PIPE_W-2:0], line_in[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= pipe_d;
    end

    assign cur[g] = pipe_q[PIPE_W-2];
    assign prv[g] = pipe_q[PIPE_W-1];
  end

  assign scl_lvl   = cur[1];
  assign sda_lvl   = cur[0];
  assign scl_rise  = ~prv[1] &  cur[1];
  assign scl_fall  =  prv[1] & ~cur[1];
  assign start_det =  prv[1] &  cur[1] &  prv[0] & ~cur[0];
  assign stop_det  =  prv[1] &  cur[1] & ~prv[0] &  cur[0];

endmodule

// File: rtl/pot_i2c_engine.sv
module pot_i2c_engine
  import pot_pkg::*;
#(
  parameter logic [4:0] DEV_TYPE = 5'b01010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       sda_lvl,
  input  logic [1:0] strap,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic [7:0] ptr,
  output eng_state_e state
);

  eng_state_e state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] tx_q, tx_d;
  logic [7:0] ptr_q, ptr_d;
  logic       oe_q, oe_d;
  logic       rw_q, rw_d;
  logic       nack_q, nack_d;
  logic       addr_hit;

  assign addr_hit = (sh_q[7:3] == DEV_TYPE) && (sh_q[2:1] == strap);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    nack_d  = nack_q;
    wr_en   = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (scl_rise) begin
      unique case (state_q)
        ST_ADDR, ST_REG, ST_WDATA: begin
          if (cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_RACK: nack_d = sda_lvl;
        default: ;
      endcase
    end else if (scl_fall) begin
      unique case (state_q)
        ST_ADDR: begin
          if (cnt_q == 4'd8) begin
            if (addr_hit) begin
              state_d = ST_ADDR_ACK;
              oe_d    = 1'b1;
              rw_d    = sh_q[0];
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          cnt_d = '0;
          if (rw_q) begin
            state_d = ST_RDATA;
            tx_d    = rd_byte;
            oe_d    = ~rd_byte[7];
          end else begin
            state_d = ST_REG;
            oe_d    = 1'b0;
          end
        end
        ST_REG: begin
          if (cnt_q == 4'd8) begin
            ptr_d   = sh_q;
            state_d = ST_REG_ACK;
            oe_d    = 1'b1;
          end
        end
        ST_WDATA: begin
          if (cnt_q == 4'd8) begin
            wr_en   = 1'b1;
            state_d = ST_WDATA_ACK;
            oe_d    = 1'b1;
          end
        end
        ST_REG_ACK, ST_WDATA_ACK: begin
          state_d = ST_WDATA;
          cnt_d   = '0;
          oe_d    = 1'b0;
        end
        ST_RDATA: begin
          if (cnt_q == 4'd7) begin
            state_d = ST_RACK;
            oe_d    = 1'b0;
          end else begin
            cnt_d = cnt_q + 4'd1;
            tx_d  = {tx_q[6:0], 1'b1};
            oe_d  = ~tx_q[6];
          end
        end
        ST_RACK: begin
          if (nack_q) begin
            state_d = ST_IGNORE;
            oe_d    = 1'b0;
          end else begin
            state_d = ST_RDATA;
            cnt_d   = '0;
            tx_d    = rd_byte;
            oe_d    = ~rd_byte[7];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '1;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_data = sh_q;
  assign ptr     = ptr_q;
  assign state   = state_q;

endmodule

// File: rtl/pot_reg_bank.sv
module pot_reg_bank #(
  parameter int             TAP_BITS  = 7,
  parameter logic [6:0]     MID_TAP   = 7'h40,
  parameter logic [7:0]     AR_ADDR   = 8'h02,
  parameter logic [7:0]     DATA_ADDR = 8'h00,
  parameter logic [7:0]     CODE_WCR  = 8'h80,
  parameter logic [7:0]     CODE_DR   = 8'h00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic [7:0]          ptr,
  output logic [7:0]          rd_byte,
  output logic                sel_wcr,
  output logic [TAP_BITS-1:0] wiper
);

  localparam int PAD_W = 8 - TAP_BITS;

  logic                sel_q, sel_d;
  logic [TAP_BITS-1:0] wcr_q, wcr_d;
  logic [TAP_BITS-1:0] dr_q, dr_d;
  logic [TAP_BITS-1:0] sel_val;

  always_comb begin
    sel_d = sel_q;
    wcr_d = wcr_q;
    dr_d  = dr_q;
    if (wr_en && ptr == AR_ADDR) begin
      if (wr_data == CODE_WCR)     sel_d = 1'b1;
      else if (wr_data == CODE_DR) sel_d = 1'b0;
    end
    if (wr_en && ptr == DATA_ADDR) begin
      if (sel_q) wcr_d = wr_data[TAP_BITS-1:0];
      else       dr_d  = wr_data[TAP_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
      wcr_q <= MID_TAP[TAP_BITS-1:0];
      dr_q  <= MID_TAP[TAP_BITS-1:0];
    end else begin
      sel_q <= sel_d;
      wcr_q <= wcr_d;
      dr_q  <= dr_d;
    end
  end

  assign sel_val = sel_q ? wcr_q : dr_q;
  assign rd_byte = (ptr == DATA_ADDR) ? {{PAD_W{1'b0}}, sel_val} : 8'hFF;
  assign sel_wcr = sel_q;
  assign wiper   = wcr_q;

endmodule

// File: rtl/pot_i2c_front.sv
module pot_i2c_front
  import pot_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         TAP_BITS    = 7,
  parameter logic [4:0] DEV_TYPE    = 5'b01010,
  parameter logic [6:0] MID_TAP     = 7'h40,
  parameter logic [7:0] AR_ADDR     = 8'h02,
  parameter logic [7:0] DATA_ADDR   = 8'h00,
  parameter logic [7:0] CODE_WCR    = 8'h80,
  parameter logic [7:0] CODE_DR     = 8'h00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [1:0]          strap_i,
  output logic                sda_oe_o,
  output logic [TAP_BITS-1:0] wiper_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en, sel_wcr;
  logic [7:0] wr_data, ptr, rd_byte;
  eng_state_e state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pot_i2c_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_linemon (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  pot_i2c_engine #(.DEV_TYPE(DEV_TYPE)) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl),
    .strap     (strap_i),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ptr       (ptr),
    .state     (state)
  );

  pot_reg_bank #(
    .TAP_BITS  (TAP_BITS),
    .MID_TAP   (MID_TAP),
    .AR_ADDR   (AR_ADDR),
    .DATA_ADDR (DATA_ADDR),
    .CODE_WCR  (CODE_WCR),
    .CODE_DR   (CODE_DR)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ptr     (ptr),
    .rd_byte (rd_byte),
    .sel_wcr (sel_wcr),
    .wiper   (wiper_o)
  );

endmodule

// File: rtl/pot_i2c_chk.sv
module pot_i2c_chk
  import pot_pkg::*;
#(
  parameter int         TAP_BITS  = 7,
  parameter logic [7:0] AR_ADDR   = 8'h02,
  parameter logic [7:0] DATA_ADDR = 8'h00,
  parameter logic [7:0] CODE_WCR  = 8'h80,
  parameter logic [7:0] CODE_DR   = 8'h00
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_lvl,
  input logic                sda_oe,
  input eng_state_e          state,
  input logic                wr_en,
  input logic [7:0]          wr_data,
  input logic [7:0]          ptr,
  input logic                sel_wcr,
  input logic [TAP_BITS-1:0] wiper
);

  assert_oe_while_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_lvl));

  assert_released_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe);

  assert_wiper_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper) |-> $past(wr_en));

  assert_unknown_code_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == AR_ADDR && wr_data != CODE_WCR && wr_data != CODE_DR)
      |=> $stable(sel_wcr));

  assert_ar_not_readable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDATA && ptr != DATA_ADDR) |-> !sda_oe);

endmodule

bind pot_i2c_front pot_i2c_chk #(
  .TAP_BITS  (TAP_BITS),
  .AR_ADDR   (AR_ADDR),
  .DATA_ADDR (DATA_ADDR),
  .CODE_WCR  (CODE_WCR),
  .CODE_DR   (CODE_DR)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .scl_lvl (scl_lvl),
  .sda_oe  (sda_oe_o),
  .state   (state),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .ptr     (ptr),
  .sel_wcr (sel_wcr),
  .wiper   (wiper_o)
);

// File: tb/tb_pot_i2c_front.sv
module tb_pot_i2c_front;

  logic       clk;
  logic       rst_n;
  logic       scl;
  logic       drv_low;
  logic       sda_bus;
  logic [1:0] strap;
  logic       sda_oe;
  logic [6:0] wiper;

  int checks;
  int fails;
  int scl_viol;

  assign sda_bus = ~(drv_low | sda_oe);

  pot_i2c_front dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .strap_i  (strap),
    .sda_oe_o (sda_oe),
    .wiper_o  (wiper)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // each row: address byte, register byte, data byte, expected ACKs, expected tap
  localparam int NV = 10;
  localparam logic [33:0] VECS [NV] = '{
    {8'h54, 8'h00, 8'h23, 3'b111, 7'h23},
    {8'h54, 8'h02, 8'h00, 3'b111, 7'h23},
    {8'h54, 8'h00, 8'h7F, 3'b111, 7'h23},
    {8'h54, 8'h02, 8'h55, 3'b111, 7'h23},
    {8'h54, 8'h00, 8'h11, 3'b111, 7'h23},
    {8'h56, 8'h00, 8'h44, 3'b000, 7'h23},
    {8'h14, 8'h00, 8'h44, 3'b000, 7'h23},
    {8'h54, 8'h02, 8'h80, 3'b111, 7'h23},
    {8'h54, 8'h00, 8'hC5, 3'b111, 7'h45},
    {8'h54, 8'h07, 8'h12, 3'b111, 7'h45}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    wait_clk(8); drv_low = 1'b0;
    wait_clk(8); scl = 1'b1;
    wait_clk(8); drv_low = 1'b1;
    wait_clk(8); scl = 1'b0;
  endtask

  task automatic bus_stop;
    wait_clk(8); drv_low = 1'b1;
    wait_clk(8); scl = 1'b1;
    wait_clk(8); drv_low = 1'b0;
    wait_clk(16);
  endtask

  task automatic put_bit(input logic b);
    wait_clk(8); drv_low = ~b;
    wait_clk(8); scl = 1'b1;
    wait_clk(16); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    wait_clk(8); drv_low = 1'b0;
    wait_clk(8); scl = 1'b1;
    wait_clk(8); ack = ~sda_bus;
    wait_clk(8); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wait_clk(8); drv_low = 1'b0;
      wait_clk(8); scl = 1'b1;
      wait_clk(8); b = {b[6:0], sda_bus};
      wait_clk(8); scl = 1'b0;
    end
    wait_clk(8); drv_low = give_ack;
    wait_clk(8); scl = 1'b1;
    wait_clk(16); scl = 1'b0;
    wait_clk(4); drv_low = 1'b0;
  endtask

  task automatic write3(input logic [7:0] a, input logic [7:0] r, input logic [7:0] d,
                        output logic [2:0] acks);
    bus_start;
    send_byte(a, acks[2]);
    send_byte(r, acks[1]);
    send_byte(d, acks[0]);
    bus_stop;
  endtask

  // set pointer, repeated START, read one byte with NACK
  task automatic ptr_read(input logic [7:0] r, output logic [7:0] b, output logic ack_rd);
    logic a0, a1;
    bus_start;
    send_byte(8'h54, a0);
    send_byte(r, a1);
    bus_start;
    send_byte(8'h55, ack_rd);
    recv_byte(1'b0, b);
    bus_stop;
  endtask

  // R11 monitor: drive enable must not move while SCL is high
  logic prev_oe, prev_scl;
  always @(negedge clk) begin
    if (rst_n && prev_scl && scl && (sda_oe !== prev_oe)) scl_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= scl;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] rb, rb2;
    logic       ak, ak2;
    checks = 0; fails = 0; scl_viol = 0;
    scl = 1'b1; drv_low = 1'b0; strap = 2'b10; rst_n = 1'b0;
    wait_clk(10);
    chk("R10 reset tap", {1'b0, wiper}, 8'h40);
    chk("R10 reset sda released", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    wait_clk(10);

    for (int v = 0; v < NV; v++) begin
      write3(VECS[v][33:26], VECS[v][25:18], VECS[v][17:10], acks);
      chk("R1 R2 R3 ack pattern", {5'd0, acks}, {5'd0, VECS[v][9:7]});
      chk("R4 R5 tap after write", {1'b0, wiper}, {1'b0, VECS[v][6:0]});
    end

    // R6 and R9: pointer 00h, repeated START, read wiper register
    ptr_read(8'h00, rb, ak);
    chk("R1 read address ack", {7'd0, ak}, 8'h01);
    chk("R6 read wiper register", rb, 8'h45);

    // select stored-data register, then read two bytes (ACK then NACK), then an extra byte
    write3(8'h54, 8'h02, 8'h00, acks);
    bus_start;
    send_byte(8'h54, ak);
    send_byte(8'h00, ak);
    bus_start;
    send_byte(8'h55, ak);
    recv_byte(1'b1, rb);
    recv_byte(1'b0, rb2);
    chk("R6 read data register", rb, 8'h11);
    chk("R6 second byte after ACK", rb2, 8'h11);
    recv_byte(1'b0, rb);
    chk("R8 released after NACK", rb, 8'hFF);
    bus_stop;

    // R7: pointer at steering register
    ptr_read(8'h02, rb, ak);
    chk("R7 address still acked", {7'd0, ak}, 8'h01);
    chk("R7 steering register unreadable", rb, 8'hFF);

    // R9: STOP in the middle of an address byte, then a normal write
    bus_start;
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop;
    chk("R9 tap kept after aborted byte", {1'b0, wiper}, 8'h45);
    write3(8'h54, 8'h02, 8'h80, acks);
    write3(8'h54, 8'h00, 8'h5A, acks);
    chk("R9 acks after abort", {5'd0, acks}, 8'h07);
    chk("R9 tap after abort", {1'b0, wiper}, 8'h5A);

    // R9: repeated START in the middle of a data byte discards it
    bus_start;
    send_byte(8'h54, ak);
    send_byte(8'h00, ak);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    bus_start;
    send_byte(8'h55, ak);
    recv_byte(1'b0, rb);
    bus_stop;
    chk("R9 restart mid data keeps wiper", rb, 8'h5A);

    // R10: reset mid-run restores selection and both registers
    rst_n = 1'b0;
    wait_clk(4);
    chk("R10 tap after second reset", {1'b0, wiper}, 8'h40);
    rst_n = 1'b1;
    wait_clk(10);
    write3(8'h54, 8'h02, 8'h00, acks);
    ptr_read(8'h00, rb, ak);
    chk("R10 data register reset value", rb, 8'h40);
    write3(8'h54, 8'h02, 8'h80, acks);
    write3(8'h54, 8'h00, 8'h33, acks);
    chk("R5 wiper write after reset", {1'b0, wiper}, 8'h33);

    chk("R11 no drive change with SCL high", scl_viol[7:0], 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule